// File: doc/BRIEF.md
# Two-Channel Lattice Wavelet Analysis Core

This block performs one analysis step of an orthonormal two-channel wavelet filter bank. The filter pair is power-symmetric, so it is built as a cascade of lattice sections rather than as a direct-form filter followed by a decimator. Each accepted input beat carries two samples of the same stream, one even-indexed and one odd-indexed. For every beat the block returns one approximation (low-pass) sample and one detail (high-pass) sample, so the halving of the sample rate is inherent. The number of sections is half the filter order and is fixed when the block is built. The reflection coefficients and the closing gain factor are build-time constants.

All arithmetic uses 16-bit two's complement samples. Coefficients and the gain factor are signed values with 14 fraction bits. Every product is rounded to nearest. Every sum clamps at the 16-bit limits. Each section holds one delayed value. The whole set of delayed values can be replaced by an external context on any accepted beat, and the updated set leaves with that beat's result. A controller can therefore run several independent streams, or several octaves, through one core without idle cycles between them.

The input and output sides are valid/ready streams. A beat is taken on a rising edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high. The pipeline moves as a single unit. `in_ready` is high whenever the last stage is empty or the consumer is taking its result. While a presented result is not taken, nothing in the block moves.

Top module: `lwf_lattice_core`

## Requirements
- R1: While reset is active and after it is released, `out_valid` is low, `in_ready` is high, and every section's delayed value is zero.
- R2: With `out_ready` held high, a beat accepted on a rising edge shows up on `out_valid`, `out_low`, `out_high` and `state_out` after N rising edges, counting the accepting edge (N = NSEC). Results leave in the order the beats were accepted.
- R3: Section i takes an upper input u and a delayed lower value d, with coefficient k. It produces upper' = sat(u + rnd(k*d)) and lower' = sat(rnd(k*u) - d), where rnd(p) = floor((p + 8192) / 16384). Section 0's upper input is `in_even`. Each later section takes its upper input from the previous section's upper'. Coefficient k of section i is K_VEC[16i+15:16i].
- R4: Any sum that exceeds the 16-bit range is clamped to 32767 or to -32768, in the stage where it occurs and at the output scaling.
- R5: `out_low` = sat(rnd(SCALE * upper_last)) and `out_high` = sat(rnd(SCALE * lower_last)), where upper_last and lower_last are the two results of the final section.
- R6: Section 0's lower input is `in_odd`. Each later section's lower input is the previous section's lower'. Without a context load, the delayed value d a section uses is the lower input it received with the previously accepted beat.
- R7: When `state_load` is high on an accepting edge, section i uses `state_in[16i+15:16i]` as d for that beat in place of its own delayed value.
- R8: Alongside each result, `state_out[16i+15:16i]` holds the lower input that section i received for that beat. This is the context to restore for the next beat of the same stream.
- R9: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_low`, `out_high` and `state_out` hold their values on the next edge.
- R10: After a beat accepted with a context load, the next beats accepted without a load continue from the context that the loaded beat left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Core can take a beat this cycle |
| in_even | input | 16 | Even-indexed sample of the pair, signed |
| in_odd | input | 16 | Odd-indexed sample of the pair, signed |
| state_load | input | 1 | Use `state_in` as the section context for this beat |
| state_in | input | 16*NSEC | Context to restore, section i at bits 16i+15:16i |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_low | output | 16 | Approximation (low-pass) sample, signed |
| out_high | output | 16 | Detail (high-pass) sample, signed |
| state_out | output | 16*NSEC | Updated context of the beat being presented |

## Verification
A context load and a stall can coincide with work already in the pipeline. A beat that swaps in a foreign context may enter while an older beat of another stream is still in a later section, and the consumer may refuse results at the same moment. The bench provokes this by mixing loaded and unloaded beats with a randomly stalling `out_ready`. It judges each cycle against a behavioural model that applies each context at acceptance time. Any mix-up of delayed values between streams, or any drift under stalls, therefore appears as a wrong output sample or a wrong `state_out`.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  localparam int SMP_W  = 16;
  localparam int FRAC_W = 14;
  localparam int ACC_W  = 2 * SMP_W + 2;

  typedef logic signed [SMP_W-1:0] smp_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  // signed product of two Q-format values, rounded to nearest, back at sample scale
  function automatic acc_t mul_rnd(input smp_t a, input smp_t b);
    acc_t p;
    p = acc_t'(a) * acc_t'(b);
    return (p + (acc_t'(1) <<< (FRAC_W - 1))) >>> FRAC_W;
  endfunction

  // clamp a wide value into the sample range
  function automatic smp_t sat(input acc_t v);
    acc_t hi;
    acc_t lo;
    hi = (acc_t'(1) <<< (SMP_W - 1)) - acc_t'(1);
    lo = -(acc_t'(1) <<< (SMP_W - 1));
    if (v > hi)      return smp_t'(hi);
    else if (v < lo) return smp_t'(lo);
    else             return smp_t'(v);
  endfunction
endpackage

// File: rtl/lwf_section.sv
module lwf_section
  import lwf_pkg::*;
#(
  parameter smp_t K = '0
) (
  input  smp_t top_i,
  input  smp_t dly_i,
  output smp_t top_o,
  output smp_t bot_o
);
  // one lattice butterfly: upper gets k times the delayed lower, lower gets k times upper minus delayed
  always_comb begin
    top_o = sat(acc_t'(top_i) + mul_rnd(K, dly_i));
    bot_o = sat(mul_rnd(K, top_i) - acc_t'(dly_i));
  end
endmodule

// File: rtl/lwf_stage.sv
module lwf_stage
  import lwf_pkg::*;
#(
  parameter int   NSEC = 2,
  parameter int   IDX  = 0,
  parameter smp_t K    = '0,
  localparam int  SV_W = NSEC * SMP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            vld_i,
  input  smp_t            top_i,
  input  smp_t            bot_i,
  input  logic            ld_i,
  input  logic [SV_W-1:0] sv_i,
  output logic            vld_o,
  output smp_t            top_o,
  output smp_t            bot_o,
  output logic            ld_o,
  output logic [SV_W-1:0] sv_o
);
  smp_t            dly_q;
  smp_t            dsel;
  smp_t            nx_top;
  smp_t            nx_bot;
  logic [SV_W-1:0] sv_nx;

  // a loaded context overrides the section's own history for this beat
  assign dsel = ld_i ? smp_t'(sv_i[IDX*SMP_W +: SMP_W]) : dly_q;

  // record the lower input of this beat as the section's new context slot
  always_comb begin
    sv_nx = sv_i;
    sv_nx[IDX*SMP_W +: SMP_W] = bot_i;
  end

  lwf_section #(.K(K)) sec_i (
    .top_i (top_i),
    .dly_i (dsel),
    .top_o (nx_top),
    .bot_o (nx_bot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      top_o <= '0;
      bot_o <= '0;
      ld_o  <= 1'b0;
      sv_o  <= '0;
      dly_q <= '0;
    end else if (adv) begin
      vld_o <= vld_i;
      if (vld_i) begin
        top_o <= nx_top;
        bot_o <= nx_bot;
        ld_o  <= ld_i;
        sv_o  <= sv_nx;
        dly_q <= bot_i;
      end
    end
  end

  // R2
  stage_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && vld_i) |=> vld_o);

  // R9
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(vld_o) && $stable(top_o) && $stable(bot_o) && $stable(sv_o)));
endmodule

// File: rtl/lwf_out_scale.sv
module lwf_out_scale
  import lwf_pkg::*;
#(
  parameter smp_t SCALE = '0
) (
  input  smp_t top_i,
  input  smp_t bot_i,
  output smp_t low_o,
  output smp_t high_o
);
  always_comb begin
    low_o  = sat(mul_rnd(SCALE, top_i));
    high_o = sat(mul_rnd(SCALE, bot_i));
  end
endmodule

// File: rtl/lwf_lattice_core.sv
module lwf_lattice_core
  import lwf_pkg::*;
#(
  parameter int                      NSEC  = 2,
  parameter logic [NSEC*SMP_W-1:0]   K_VEC = 32'h24F3_9126,
  parameter smp_t                    SCALE = 16'sh1BB6,
  localparam int                     SV_W  = NSEC * SMP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [SMP_W-1:0] in_even,
  input  logic signed [SMP_W-1:0] in_odd,
  input  logic                    state_load,
  input  logic [SV_W-1:0]         state_in,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [SMP_W-1:0] out_low,
  output logic signed [SMP_W-1:0] out_high,
  output logic [SV_W-1:0]         state_out
);
  logic            vld_c [NSEC+1];
  smp_t            top_c [NSEC+1];
  smp_t            bot_c [NSEC+1];
  logic [SV_W-1:0] sv_c  [NSEC+1];
  logic            ld_c  [NSEC];
  logic            ld_unused;
  logic            adv;

  // whole pipeline moves together; it stalls only when a result waits
  assign adv      = !vld_c[NSEC] || out_ready;
  assign in_ready = adv;

  assign vld_c[0] = in_valid;
  assign top_c[0] = in_even;
  assign bot_c[0] = in_odd;
  assign sv_c[0]  = state_in;
  assign ld_c[0]  = state_load;

  for (genvar i = 0; i < NSEC; i++) begin : g_sec
    if (i < NSEC - 1) begin : g_mid
      lwf_stage #(.NSEC(NSEC), .IDX(i), .K(smp_t'(K_VEC[i*SMP_W +: SMP_W]))) stg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .vld_i (vld_c[i]),
        .top_i (top_c[i]),
        .bot_i (bot_c[i]),
        .ld_i  (ld_c[i]),
        .sv_i  (sv_c[i]),
        .vld_o (vld_c[i+1]),
        .top_o (top_c[i+1]),
        .bot_o (bot_c[i+1]),
        .ld_o  (ld_c[i+1]),
        .sv_o  (sv_c[i+1])
      );
    end else begin : g_last
      lwf_stage #(.NSEC(NSEC), .IDX(i), .K(smp_t'(K_VEC[i*SMP_W +: SMP_W]))) stg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .vld_i (vld_c[i]),
        .top_i (top_c[i]),
        .bot_i (bot_c[i]),
        .ld_i  (ld_c[i]),
        .sv_i  (sv_c[i]),
        .vld_o (vld_c[i+1]),
        .top_o (top_c[i+1]),
        .bot_o (bot_c[i+1]),
        .ld_o  (ld_unused),
        .sv_o  (sv_c[i+1])
      );
    end
  end

  lwf_out_scale #(.SCALE(SCALE)) scl_i (
    .top_i  (top_c[NSEC]),
    .bot_i  (bot_c[NSEC]),
    .low_o  (out_low),
    .high_o (out_high)
  );

  assign out_valid = vld_c[NSEC];
  assign state_out = sv_c[NSEC];

  // R9
  out_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_low) && $stable(out_high) && $stable(state_out)));

  // R5
  zero_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && top_c[NSEC] == '0 && bot_c[NSEC] == '0) |-> (out_low == '0 && out_high == '0));
endmodule

// File: tb/lwf_lattice_core_tb_top.sv
module lwf_lattice_core_tb_top;
  localparam int          NS  = 2;
  localparam logic [31:0] KV  = 32'h24F3_9126;
  localparam int          SCL = 7094;
  localparam int          SVW = NS * 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [15:0]     in_even = '0;
  logic [15:0]     in_odd = '0;
  logic            state_load = 1'b0;
  logic [SVW-1:0]  state_in = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [15:0]     out_low;
  logic [15:0]     out_high;
  logic [SVW-1:0]  state_out;

  int    checks = 0;
  int    errors = 0;
  int    bp = 0;
  string tag = "R1";

  int             md    [NS];
  bit             sl_v  [NS];
  int             sl_lo [NS];
  int             sl_hi [NS];
  logic [SVW-1:0] sl_st [NS];
  bit             m_adv;

  always #4 clk = ~clk;

  lwf_lattice_core #(.NSEC(NS), .K_VEC(KV), .SCALE(16'(SCL))) dut_i (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .in_even (in_even), .in_odd (in_odd),
    .state_load (state_load), .state_in (state_in),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_low (out_low), .out_high (out_high),
    .state_out (state_out)
  );

  function automatic int rnd14(input int p);
    return (p + 8192) >>> 14;
  endfunction

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int kof(input int i);
    logic [15:0] w;
    w = KV[i*16 +: 16];
    return int'($signed(w));
  endfunction

  function automatic int s16(input logic [15:0] w);
    return int'($signed(w));
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // behavioural reference: apply the whole lattice to one beat at acceptance
  task automatic model_beat(input int e, input int o, input bit ld, input logic [SVW-1:0] st,
                            output int lo, output int hi, output logic [SVW-1:0] nst);
    int u;
    int b;
    int d;
    int u2;
    u = e;
    b = o;
    nst = '0;
    for (int i = 0; i < NS; i++) begin
      d = ld ? s16(st[i*16 +: 16]) : md[i];
      nst[i*16 +: 16] = b[15:0];
      md[i] = b;
      u2 = sat16(u + rnd14(kof(i) * d));
      b  = sat16(rnd14(kof(i) * u) - d);
      u  = u2;
    end
    lo = sat16(rnd14(u * SCL));
    hi = sat16(rnd14(b * SCL));
  endtask

  // cycle model: same acceptance and stall rule as the ports promise
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) begin
        md[i] = 0; sl_v[i] = 1'b0; sl_lo[i] = 0; sl_hi[i] = 0; sl_st[i] = '0;
      end
    end else begin
      m_adv = !sl_v[NS-1] || out_ready;
      if (m_adv) begin
        for (int i = NS - 1; i > 0; i--) begin
          sl_v[i] = sl_v[i-1]; sl_lo[i] = sl_lo[i-1]; sl_hi[i] = sl_hi[i-1]; sl_st[i] = sl_st[i-1];
        end
        sl_v[0] = in_valid;
        if (in_valid)
          model_beat(s16(in_even), s16(in_odd), state_load, state_in, sl_lo[0], sl_hi[0], sl_st[0]);
      end
      #1;
      chk(out_valid === sl_v[NS-1], "R2/R9 out_valid", int'(out_valid), int'(sl_v[NS-1]));
      chk(in_ready === (!sl_v[NS-1] || out_ready), "R9 in_ready", int'(in_ready),
          int'(!sl_v[NS-1] || out_ready));
      if (out_valid && sl_v[NS-1]) begin
        chk(s16(out_low) == sl_lo[NS-1], {tag, " out_low"}, s16(out_low), sl_lo[NS-1]);
        chk(s16(out_high) == sl_hi[NS-1], {tag, " out_high"}, s16(out_high), sl_hi[NS-1]);
        chk(state_out === sl_st[NS-1], "R8 state_out", int'(state_out), int'(sl_st[NS-1]));
      end
    end
  end

  task automatic send(input int e, input int o, input bit ld, input logic [SVW-1:0] st);
    bit acc;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      out_ready  = ($urandom_range(99) >= bp);
      in_valid   = 1'b1;
      in_even    = e[15:0];
      in_odd     = o[15:0];
      state_load = ld;
      state_in   = st;
      #1;
      acc = in_ready;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid   = 1'b0;
      state_load = 1'b0;
      out_ready  = ($urandom_range(99) >= bp);
    end
  endtask

  function automatic int rsmall();
    return int'($urandom_range(8000)) - 4000;
  endfunction

  function automatic int rfull();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  function automatic logic [SVW-1:0] rctx();
    logic [SVW-1:0] v;
    for (int i = 0; i < NS; i++) v[i*16 +: 16] = 16'($urandom_range(65535));
    return v;
  endfunction

  initial begin
    int lat;
    bit seen;
    logic [15:0] held;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R1: idle after reset
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    // R1/R6: first beat uses all-zero history
    tag = "R1/R6";
    send(1000, -500, 1'b0, '0);
    idle(4);

    // R2: latency of NS edges counting the accepting one
    tag = "R2";
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_even = 16'd300; in_odd = 16'd77; state_load = 1'b0;
    @(posedge clk); #2;
    lat = 1; seen = out_valid;
    @(negedge clk); in_valid = 1'b0;
    while (!seen && lat < 10) begin
      @(posedge clk); #2;
      lat++;
      seen = out_valid;
    end
    chk(lat == NS, "R2 latency", lat, NS);
    idle(4);

    // R3/R6: back-to-back stream
    tag = "R3/R6";
    bp = 0;
    for (int n = 0; n < 30; n++) send(rsmall(), rsmall(), 1'b0, '0);
    idle(4);

    // R9: random stalls on the output side
    tag = "R9/R3";
    bp = 50;
    for (int n = 0; n < 40; n++) send(rfull(), rfull(), 1'b0, '0);
    bp = 0;
    idle(6);

    // R9: directed hold while the consumer refuses
    tag = "R9";
    send(2500, -1200, 1'b0, '0);
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b0;
    repeat (NS + 1) @(negedge clk);
    held = out_low;
    repeat (3) begin
      @(posedge clk); #2;
      chk(out_valid == 1'b1 && out_low == held, "R9 hold", s16(out_low), s16(held));
      chk(in_ready == 1'b0, "R9 ready low", int'(in_ready), 0);
    end
    idle(4);

    // R4: extremes force clamping
    tag = "R4";
    send(32767, 32767, 1'b0, '0);
    send(-32768, -32768, 1'b0, '0);
    send(32767, -32768, 1'b0, '0);
    send(-32768, 32767, 1'b0, '0);
    send(32767, 32767, 1'b0, '0);
    send(32767, 32767, 1'b1, {NS{16'h7FFF}});
    send(-32768, -32768, 1'b1, {NS{16'h8000}});
    idle(4);

    // R7/R8: context swaps interleaved with stalls
    tag = "R7/R8";
    bp = 40;
    for (int n = 0; n < 12; n++) send(rfull(), rfull(), n[0], rctx());
    bp = 0;
    idle(6);

    // R10: loaded beat, then continuation without load
    tag = "R10";
    send(rsmall(), rsmall(), 1'b1, rctx());
    for (int n = 0; n < 6; n++) send(rsmall(), rsmall(), 1'b0, '0);
    idle(4);

    // R5: zero beat with zero context gives zero outputs
    tag = "R5";
    send(0, 0, 1'b1, '0);
    send(16384, 0, 1'b1, '0);
    send(0, 16384, 1'b0, '0);
    idle(6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule